// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from the reference clock. It offers two ways to set the divide ratio. The cascaded mode uses a 4-bit pre-scale field that divides by the field value plus one, followed by a power-of-two stage set by a 4-bit exponent field. The legacy mode uses a 3-bit rate code. A mode input selects between the two.

The block produces three outputs. The first is a single-cycle divider tick at the divided rate. The second is a pair of strobes that mark the coming rising or falling SCLK edge, so that a shift engine can sample and drive in the reference clock domain. The third is the SCLK level itself. The counters run only while the enable input and the burst-active input are both high. In every other cycle they are held at zero, and SCLK rests at the idle level programmed for the selected chip select. Each chip select has its own polarity bit and its own idle-level bit.

Top module: `spi_clk_div`

## Requirements
- R1: In cascaded mode (`legacyMode`=0), `divTick` is high once every N cycles, where N = (`preDiv`+1) × 2^`postDiv`.
- R2: In legacy mode (`legacyMode`=1), `divTick` is high once every 4 × 2^`rateCode` cycles.
- R3: In cascaded mode with both divider fields at zero, `divTick` is high in every active cycle.
- R4: The counters restart at the beginning of every burst. The first tick therefore falls in cycle N-1, where cycle 0 is the first cycle in which both `enable` and `burstActive` are high.
- R5: During a burst, SCLK starts at `sclkPolarity[csSel]`. It inverts at the clock edge that ends each tick cycle and holds its level in every other cycle.
- R6: `riseStb` is high exactly in tick cycles where SCLK is currently 0. `fallStb` is high exactly in tick cycles where SCLK is currently 1.
- R7: While `enable` or `burstActive` is low, SCLK equals `sclkIdle[csSel]`, and `divTick`, `riseStb` and `fallStb` are all low.
- R8: If `enable` drops in the middle of a burst, the divider resets at once. When `enable` returns, the next half period has its full length of N cycles.
- R9: Polarity and idle level are taken only from bit `csSel` of their vectors. The bits for the other chip selects have no effect.
- R10: In legacy mode, the values of `preDiv` and `postDiv` have no effect on the tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low resets the divider |
| burstActive | input | 1 | High while a transfer burst is in progress |
| legacyMode | input | 1 | 1 selects the rate-code ratio, 0 the cascaded ratio |
| preDiv | input | PRE_W | Pre-scale field; divide by value+1 |
| postDiv | input | POST_W | Power-of-two exponent field |
| rateCode | input | CODE_W | Legacy code n; ratio 4<<n |
| csSel | input | CS_W | Selected chip select |
| sclkPolarity | input | NUM_CS | Starting SCLK level of a burst, one bit per chip select |
| sclkIdle | input | NUM_CS | Resting SCLK level, one bit per chip select |
| divTick | output | 1 | Divided clock enable |
| riseStb | output | 1 | SCLK rises at the end of this cycle |
| fallStb | output | 1 | SCLK falls at the end of this cycle |
| sclk | output | 1 | Serial clock level |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- **Ratio of one.** A divider that does not special-case a ratio of 1 would tick only every other cycle.
- **Odd pre-scale under a power-of-two stage.** A ratio of 6 catches a design that applies the exponent to the wrong stage.
- **Legacy mode with nonzero fields.** A legacy burst run with nonzero `preDiv` and `postDiv` exposes a mode mux that lets those fields leak into the ratio.
- **Mid-burst enable drop.** This catches a divider that keeps its count and then produces a short first half period after `enable` returns.
- **Mismatched chip-select bits.** Every chip select other than the selected one carries the opposite polarity and idle bits, so a design that reads the wrong index shows an inverted SCLK.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;
  // Strobes passed from the counter control to the SCLK datapath
  typedef struct packed {
    logic restart;  // divider held idle this cycle
    logic tick;     // divided clock enable
  } divStb_t;

  // Legacy mode: fixed divide-by-four first stage
  localparam int LEGACY_PRE = 3;
endpackage

// File: rtl/spi_clk_div_ctrl.sv
module spi_clk_div_ctrl
  import spi_clk_div_pkg::*;
#(
  parameter int PRE_W  = 4,
  parameter int POST_W = 4,
  parameter int CODE_W = 3,
  localparam int POSTCNT_W = (1 << POST_W) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              burstActive,
  input  logic              legacyMode,
  input  logic [PRE_W-1:0]  preDiv,
  input  logic [POST_W-1:0] postDiv,
  input  logic [CODE_W-1:0] rateCode,
  output divStb_t           stb
);
  logic                 active;
  logic [PRE_W-1:0]     effPre;
  logic [POST_W-1:0]    effPost;
  logic [PRE_W-1:0]     preCnt;
  logic [POSTCNT_W-1:0] postCnt;
  logic [POSTCNT_W-1:0] postMask;
  logic                 preHit;
  logic                 postHit;

  assign active = enable & burstActive;

  // Mode select: legacy uses a fixed /4 stage with the code as exponent
  always_comb begin
    if (legacyMode) begin
      effPre  = PRE_W'(LEGACY_PRE);
      effPost = POST_W'(rateCode);
    end else begin
      effPre  = preDiv;
      effPost = postDiv;
    end
  end

  // Low effPost bits of the second-stage count must be all ones for a tick
  for (genvar i = 0; i < POSTCNT_W; i++) begin : gMask
    assign postMask[i] = (int'(effPost) > i);
  end

  assign preHit  = (preCnt == effPre);
  assign postHit = ((postCnt & postMask) == postMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      postCnt <= '0;
    end else if (!active) begin
      preCnt  <= '0;
      postCnt <= '0;
    end else if (preHit) begin
      preCnt  <= '0;
      postCnt <= postHit ? '0 : postCnt + 1'b1;
    end else begin
      preCnt  <= preCnt + 1'b1;
    end
  end

  assign stb.restart = ~active;
  assign stb.tick    = active & preHit & postHit;

  AST_START_FRESH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> (preCnt == '0 && postCnt == '0)); // R4

  AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && $stable(effPre) && $past(preCnt == effPre))
      |-> (preCnt == '0)); // R1
endmodule

// File: rtl/spi_clk_div_dp.sv
module spi_clk_div_dp
  import spi_clk_div_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStb_t           stb,
  input  logic [CS_W-1:0]   csSel,
  input  logic [NUM_CS-1:0] sclkPolarity,
  input  logic [NUM_CS-1:0] sclkIdle,
  output logic              sclk,
  output logic              riseStb,
  output logic              fallStb
);
  logic polBit;
  logic idleBit;
  logic phase;
  logic sclkRun;

  assign polBit  = sclkPolarity[csSel];
  assign idleBit = sclkIdle[csSel];

  // Phase counts half periods since burst start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           phase <= 1'b0;
    else if (stb.restart) phase <= 1'b0;
    else if (stb.tick)    phase <= ~phase;
  end

  assign sclkRun = polBit ^ phase;
  assign sclk    = stb.restart ? idleBit : sclkRun;
  assign riseStb = stb.tick & ~sclkRun;
  assign fallStb = stb.tick &  sclkRun;

  AST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    stb.tick |=> (stb.restart || !$stable(polBit) || sclk != $past(sclk))); // R5

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.tick && !stb.restart) |=> (stb.restart || !$stable(polBit) || $stable(sclk))); // R5

  AST_RISE_LEADS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |=> (stb.restart || !$stable(polBit) || sclk)); // R6

  AST_FALL_LEADS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |=> (stb.restart || !$stable(polBit) || !sclk)); // R6
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_clk_div_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int PRE_W  = 4,
  parameter int POST_W = 4,
  parameter int CODE_W = 3,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              burstActive,
  input  logic              legacyMode,
  input  logic [PRE_W-1:0]  preDiv,
  input  logic [POST_W-1:0] postDiv,
  input  logic [CODE_W-1:0] rateCode,
  input  logic [CS_W-1:0]   csSel,
  input  logic [NUM_CS-1:0] sclkPolarity,
  input  logic [NUM_CS-1:0] sclkIdle,
  output logic              divTick,
  output logic              riseStb,
  output logic              fallStb,
  output logic              sclk
);
  divStb_t stb;

  spi_clk_div_ctrl #(.PRE_W(PRE_W), .POST_W(POST_W), .CODE_W(CODE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .burstActive(burstActive),
    .legacyMode(legacyMode), .preDiv(preDiv), .postDiv(postDiv),
    .rateCode(rateCode), .stb(stb)
  );

  spi_clk_div_dp #(.NUM_CS(NUM_CS)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .csSel(csSel),
    .sclkPolarity(sclkPolarity), .sclkIdle(sclkIdle),
    .sclk(sclk), .riseStb(riseStb), .fallStb(fallStb)
  );

  assign divTick = stb.tick;
endmodule

// File: tb/spi_clk_div_tb_top.sv
module spi_clk_div_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       burstActive = 1'b0;
  logic       legacyMode = 1'b0;
  logic [3:0] preDiv = '0;
  logic [3:0] postDiv = '0;
  logic [2:0] rateCode = '0;
  logic [1:0] csSel = '0;
  logic [3:0] sclkPolarity = '0;
  logic [3:0] sclkIdle = '0;
  logic       divTick, riseStb, fallStb, sclk;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_clk_div dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .burstActive(burstActive),
    .legacyMode(legacyMode), .preDiv(preDiv), .postDiv(postDiv),
    .rateCode(rateCode), .csSel(csSel), .sclkPolarity(sclkPolarity),
    .sclkIdle(sclkIdle), .divTick(divTick), .riseStb(riseStb),
    .fallStb(fallStb), .sclk(sclk)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  // Assumes the burst became active at the current negedge (cycle 0)
  task automatic checkRun(string req, int n, logic pol, int cycles);
    for (int k = 0; k < cycles; k++) begin
      logic expTick, expS;
      #1;
      expTick = ((k + 1) % n) == 0;
      expS    = pol ^ logic'((k / n) % 2);
      chk((k == n - 1) ? "R4" : req, "divTick", divTick, expTick);
      chk("R5", "sclk", sclk, expS);
      chk("R6", "riseStb", riseStb, expTick & ~expS);
      chk("R6", "fallStb", fallStb, expTick & expS);
      @(negedge clk);
    end
  endtask

  // Other chip selects carry opposite bits to catch wrong indexing (R9)
  task automatic setup(logic m, int pre, int post, int code, int cs, logic pol, logic idl);
    @(negedge clk);
    legacyMode   = m;
    preDiv       = 4'(pre);
    postDiv      = 4'(post);
    rateCode     = 3'(code);
    csSel        = 2'(cs);
    sclkPolarity = {4{~pol}};
    sclkPolarity[cs] = pol;
    sclkIdle     = {4{~idl}};
    sclkIdle[cs] = idl;
    enable       = 1'b1;
  endtask

  task automatic runBurst(string req, logic m, int pre, int post, int code,
                          int cs, logic pol, logic idl, int n);
    setup(m, pre, post, code, cs, pol, idl);
    #1;
    chk("R7", "sclk before burst", sclk, idl);
    chk("R9", "sclk idle index", sclk, idl);
    @(negedge clk);
    burstActive = 1'b1;
    checkRun(req, n, pol, 2 * n + 2);
    burstActive = 1'b0;
    #1;
    chk("R7", "sclk after burst", sclk, idl);
    chk("R7", "divTick after burst", divTick, 1'b0);
  endtask

  task automatic testReset();
    sclkIdle = 4'b0001;
    enable   = 1'b1;
    #1;
    chk("R7", "sclk in reset", sclk, 1'b1);
    chk("R7", "divTick in reset", divTick, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R7", "sclk after reset", sclk, 1'b1);
  endtask

  task automatic testIdle();
    @(negedge clk);
    enable = 1'b1; burstActive = 1'b0;
    sclkIdle = 4'b0101; sclkPolarity = 4'b1010;
    for (int c = 0; c < 4; c++) begin
      csSel = 2'(c);
      #1;
      chk("R9", "idle per cs", sclk, sclkIdle[c]);
      chk("R7", "no tick idle", divTick, 1'b0);
      @(negedge clk);
    end
    // enable low with burst requested: still parked
    enable = 1'b0; burstActive = 1'b1; csSel = 2'd1;
    for (int c = 0; c < 5; c++) begin
      #1;
      chk("R7", "sclk disabled", sclk, 1'b0);
      chk("R7", "tick disabled", divTick, 1'b0);
      chk("R7", "strobes disabled", riseStb | fallStb, 1'b0);
      @(negedge clk);
    end
    burstActive = 1'b0;
  endtask

  task automatic testEnableDrop();
    setup(1'b0, 2, 1, 0, 2, 1'b0, 1'b1);
    @(negedge clk);
    burstActive = 1'b1;
    checkRun("R1", 6, 1'b0, 8);
    enable = 1'b0;
    #1;
    chk("R8", "sclk on enable drop", sclk, 1'b1);
    chk("R8", "tick on enable drop", divTick, 1'b0);
    @(negedge clk);
    enable = 1'b1;
    checkRun("R8", 6, 1'b0, 14);
    burstActive = 1'b0;
  endtask

  initial begin
    testReset();
    testIdle();
    runBurst("R3",  1'b0, 0,  0, 0, 0, 1'b0, 1'b0, 1);
    runBurst("R1",  1'b0, 2,  1, 0, 1, 1'b1, 1'b0, 6);
    runBurst("R1",  1'b0, 0,  3, 0, 2, 1'b0, 1'b1, 8);
    runBurst("R1",  1'b0, 15, 0, 0, 3, 1'b1, 1'b1, 16);
    runBurst("R1",  1'b0, 4,  2, 0, 2, 1'b1, 1'b0, 20);
    runBurst("R2",  1'b1, 0,  0, 0, 0, 1'b0, 1'b1, 4);
    runBurst("R10", 1'b1, 9,  7, 2, 1, 1'b1, 1'b0, 16);
    runBurst("R2",  1'b1, 3,  1, 1, 3, 1'b0, 1'b0, 8);
    testEnableDrop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule